// File: doc/BRIEF.md
# Tuner Control Register Bank

This block is the byte-wide register file that sits between a serial slave protocol engine and the analog front end of a television tuner. The protocol engine presents decoded register writes (a strobe, a 4-bit register number and a data byte) and register reads (a strobe and a register number). It also signals when the byte it fetched has been completely shifted out on the wire. The bank drives the tracking-filter capacitor codes and the filter ROM address to the analog side. It returns register contents through a single registered read-data port.

Three registers hold tracking-filter settings: a series-capacitor code, a parallel-capacitor code together with a load bit, and a ROM address. A rising edge of the load bit copies one word of a constant on-chip table into a read-only readback register. A status register reports the 3-bit VCO tuning indicator from the PLL, registered once, and a sticky power-on flag. The flag is set by reset and cleared only once a status byte has actually been delivered. The indicator is also decoded into three outputs that tell the tuning software whether the PLL is locked or which way to move the sub-band.

Top module: `tuner_ctl_regs`

## Requirements
- R1: While reset is low, and after it is released, series_cap reads 0x0F, par_cap 0x09, rom_addr 0, the load bit 0, the readback register 0, rd_data 0, and the power-on flag is 1.
- R2: A write to register 0x7 replaces the full 8-bit series-capacitor code, which appears on series_cap on the next cycle and reads back unchanged; with no such write series_cap holds.
- R3: A write to register 0x8 stores data bits 5..0 as the parallel-capacitor code and bit 7 as the load bit, and a read returns {load, 0, code}. A write to register 0x9 stores bits 3..0 as the ROM address (also driven on rom_addr), and a read returns {0000, address}.
- R4: A write to 0x8 with bit 7 set while the stored load bit is 0 loads register 0xB, on the next cycle, with the table word at the current ROM address a, equal to (29*a + 7) mod 256.
- R5: Register 0xB changes only through R4: writing bit 7 as 1 while the load bit is already 1, or writing it as 0, leaves 0xB unchanged.
- R6: Writes to 0xA, 0xB, 0xC and to the unmapped registers 0x0-0x6 and 0xD-0xF change no state. Reads of 0xA and of the unmapped registers return 0x00.
- R7: A read strobe captures the addressed register, with values before any same-cycle write, into rd_data on the next cycle. rd_data holds until the next read strobe.
- R8: Register 0xC reads as {power-on flag, lock indicator, 0000}. The lock indicator in bits 6..4 is pll_lock as sampled on the previous clock edge.
- R9: The power-on flag clears when rd_done pulses while the most recent read strobe addressed 0xC. A read strobe alone does not clear it. Once clear, it stays 0 until the next reset.
- R10: From the registered lock indicator, band_down is 1 for 000, band_up is 1 for 111, and pll_locked is 1 for 001 to 110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| wr_stb | input | 1 | Register write strobe, one cycle |
| wr_addr | input | 4 | Register number for the write |
| wr_data | input | 8 | Write data byte |
| rd_stb | input | 1 | Register read strobe, one cycle |
| rd_addr | input | 4 | Register number for the read |
| rd_done | input | 1 | Pulse: the captured read byte has been completely shifted out |
| pll_lock | input | 3 | VCO tuning indicator from the PLL |
| rd_data | output | 8 | Registered read data |
| series_cap | output | 8 | Series-capacitor code |
| par_cap | output | 6 | Parallel-capacitor code |
| rom_addr | output | 4 | Filter ROM address |
| pll_locked | output | 1 | PLL locked |
| band_down | output | 1 | Not locked, move down one sub-band |
| band_up | output | 1 | Not locked, move up one sub-band |

## Verification
The assertions check on every cycle the properties that follow from a single edge. The readback register changes only on a load-bit rising edge, and when it does it holds the table word. The power-on flag never rises outside reset and never falls without rd_done. rd_data and series_cap hold when not strobed, the reserved status bits are zero, and the band decode follows the sampled indicator. Some behaviour needs multi-step sequences that only the bench scenarios build: a load-bit rewrite that must not reload, a status read that must leave the flag set until the byte is delivered, ignored writes to read-only and reserved registers, read-before-write ordering in one cycle, and the flag returning after a second reset.

// File: rtl/tuner_ctl_pkg.sv
package tuner_ctl_pkg;

    parameter int REG_W  = 8;
    parameter int ADDR_W = 4;
    parameter int LOCK_W = 3;
    parameter int PCAP_W = 6;
    parameter int ROMA_W = 4;

    localparam int ROM_N = 1 << ROMA_W;

    localparam logic [ADDR_W-1:0] A_SER  = ADDR_W'(7);
    localparam logic [ADDR_W-1:0] A_PAR  = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] A_TFA  = ADDR_W'(9);
    localparam logic [ADDR_W-1:0] A_RSV  = ADDR_W'(10);
    localparam logic [ADDR_W-1:0] A_RB   = ADDR_W'(11);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(12);

    localparam logic [REG_W-1:0]  SER_RST = REG_W'(8'h0F);
    localparam logic [PCAP_W-1:0] PAR_RST = PCAP_W'(6'b001001);

    // Constant filter table: word(a) = 29*a + 7, truncated to a byte
    function automatic logic [REG_W-1:0] rom_word(input int a);
        return REG_W'((a * 29 + 7) % 256);
    endfunction

    typedef struct packed {
        logic [REG_W-1:0]  ser;
        logic [PCAP_W-1:0] par;
        logic              fld;
        logic [ROMA_W-1:0] tfa;
        logic [REG_W-1:0]  rb;
    } filt_st_t;

    typedef struct packed {
        logic [LOCK_W-1:0] lock;
        logic              por;
        logic              src_stat;
    } stat_st_t;

    typedef struct packed {
        logic [REG_W-1:0] data;
    } rd_st_t;

endpackage

// File: rtl/tuner_ctl_filter.sv
module tuner_ctl_filter
    import tuner_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  ser_q,
    output logic [PCAP_W-1:0] par_q,
    output logic              fld_q,
    output logic [ROMA_W-1:0] tfa_q,
    output logic [REG_W-1:0]  rb_q
);

    localparam int LOAD_BIT = REG_W - 1;

    logic [REG_W-1:0] rom_w [ROM_N];

    for (genvar gi = 0; gi < ROM_N; gi++) begin : g_rom
        assign rom_w[gi] = rom_word(gi);
    end

    filt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_stb) begin
            case (wr_addr)
                A_SER: st_d.ser = wr_data;
                A_PAR: begin
                    st_d.par = wr_data[PCAP_W-1:0];
                    st_d.fld = wr_data[LOAD_BIT];
                    if (wr_data[LOAD_BIT] && !st_q.fld) begin
                        st_d.rb = rom_w[st_q.tfa];
                    end
                end
                A_TFA: st_d.tfa = wr_data[ROMA_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ser: SER_RST, par: PAR_RST, fld: 1'b0, tfa: '0, rb: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_q = st_q.ser;
    assign par_q = st_q.par;
    assign fld_q = st_q.fld;
    assign tfa_q = st_q.tfa;
    assign rb_q  = st_q.rb;

endmodule

// File: rtl/tuner_ctl_status.sv
module tuner_ctl_status
    import tuner_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_done,
    input  logic [LOCK_W-1:0] pll_lock,
    output logic [LOCK_W-1:0] lock_q,
    output logic              por_q,
    output logic              pll_locked,
    output logic              band_down,
    output logic              band_up
);

    stat_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.lock = pll_lock;
        // clear only when the delivered byte was a status byte
        if (rd_done && st_q.src_stat) begin
            st_d.por = 1'b0;
        end
        if (rd_stb) begin
            st_d.src_stat = (rd_addr == A_STAT);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{lock: '0, por: 1'b1, src_stat: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign lock_q     = st_q.lock;
    assign por_q      = st_q.por;
    assign band_down  = (st_q.lock == '0);
    assign band_up    = (st_q.lock == '1);
    assign pll_locked = !band_down && !band_up;

endmodule

// File: rtl/tuner_ctl_rdport.sv
module tuner_ctl_rdport
    import tuner_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [REG_W-1:0]  ser,
    input  logic [PCAP_W-1:0] par,
    input  logic              fld,
    input  logic [ROMA_W-1:0] tfa,
    input  logic [REG_W-1:0]  rb,
    input  logic [LOCK_W-1:0] lock,
    input  logic              por,
    output logic [REG_W-1:0]  rd_data
);

    localparam int PAR_PAD  = REG_W - PCAP_W - 1;
    localparam int TFA_PAD  = REG_W - ROMA_W;
    localparam int STAT_PAD = REG_W - LOCK_W - 1;

    rd_st_t st_d, st_q;
    logic [REG_W-1:0] mux_w;

    always_comb begin
        case (rd_addr)
            A_SER:   mux_w = ser;
            A_PAR:   mux_w = {fld, {PAR_PAD{1'b0}}, par};
            A_TFA:   mux_w = {{TFA_PAD{1'b0}}, tfa};
            A_RB:    mux_w = rb;
            A_STAT:  mux_w = {por, lock, {STAT_PAD{1'b0}}};
            default: mux_w = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (rd_stb) begin
            st_d.data = mux_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{data: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.data;

endmodule

// File: rtl/tuner_ctl_regs.sv
module tuner_ctl_regs
    import tuner_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_done,
    input  logic [LOCK_W-1:0] pll_lock,
    output logic [REG_W-1:0]  rd_data,
    output logic [REG_W-1:0]  series_cap,
    output logic [PCAP_W-1:0] par_cap,
    output logic [ROMA_W-1:0] rom_addr,
    output logic              pll_locked,
    output logic              band_down,
    output logic              band_up
);

    logic [REG_W-1:0]  ser_w;
    logic [PCAP_W-1:0] par_w;
    logic              fld_w;
    logic [ROMA_W-1:0] tfa_w;
    logic [REG_W-1:0]  rb_w;
    logic [LOCK_W-1:0] lock_w;
    logic              por_w;

    tuner_ctl_filter u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ser_q   (ser_w),
        .par_q   (par_w),
        .fld_q   (fld_w),
        .tfa_q   (tfa_w),
        .rb_q    (rb_w)
    );

    tuner_ctl_status u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_stb     (rd_stb),
        .rd_addr    (rd_addr),
        .rd_done    (rd_done),
        .pll_lock   (pll_lock),
        .lock_q     (lock_w),
        .por_q      (por_w),
        .pll_locked (pll_locked),
        .band_down  (band_down),
        .band_up    (band_up)
    );

    tuner_ctl_rdport u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_stb  (rd_stb),
        .rd_addr (rd_addr),
        .ser     (ser_w),
        .par     (par_w),
        .fld     (fld_w),
        .tfa     (tfa_w),
        .rb      (rb_w),
        .lock    (lock_w),
        .por     (por_w),
        .rd_data (rd_data)
    );

    assign series_cap = ser_w;
    assign par_cap    = par_w;
    assign rom_addr   = tfa_w;

endmodule

// File: rtl/tuner_ctl_regs_chk.sv
module tuner_ctl_regs_chk
    import tuner_ctl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [REG_W-1:0]  wr_data,
    input logic              rd_stb,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_done,
    input logic [LOCK_W-1:0] pll_lock,
    input logic [REG_W-1:0]  rd_data,
    input logic [REG_W-1:0]  series_cap,
    input logic              fld,
    input logic [ROMA_W-1:0] tfa,
    input logic [REG_W-1:0]  rb,
    input logic              por,
    input logic              pll_locked,
    input logic              band_up
);

    logic load_edge;
    assign load_edge = wr_stb && (wr_addr == A_PAR) && wr_data[REG_W-1] && !fld;

    p_load_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_edge |=> (rb == rom_word(int'($past(tfa)))));

    p_rb_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_edge |=> $stable(rb));

    p_ser_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && wr_addr == A_SER) |=> $stable(series_cap));

    p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));

    p_stat_rsv_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rd_addr == A_STAT) |=> (rd_data[3:0] == 4'h0));

    p_por_no_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !por |=> !por);

    p_por_needs_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (por && !rd_done) |=> por);

    p_band_up_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        band_up |-> ($past(pll_lock) == '1));

    p_locked_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pll_locked |-> ($past(pll_lock) != '1 && $past(pll_lock) != '0));

endmodule

bind tuner_ctl_regs tuner_ctl_regs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (wr_stb),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_stb     (rd_stb),
    .rd_addr    (rd_addr),
    .rd_done    (rd_done),
    .pll_lock   (pll_lock),
    .rd_data    (rd_data),
    .series_cap (series_cap),
    .fld        (fld_w),
    .tfa        (tfa_w),
    .rb         (rb_w),
    .por        (por_w),
    .pll_locked (pll_locked),
    .band_up    (band_up)
);

// File: tb/sim_tuner_ctl_regs.sv
`timescale 1ns/1ps
module sim_tuner_ctl_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_stb = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_stb = 1'b0;
    logic [3:0] rd_addr = '0;
    logic       rd_done = 1'b0;
    logic [2:0] pll_lock = 3'b010;
    logic [7:0] rd_data;
    logic [7:0] series_cap;
    logic [5:0] par_cap;
    logic [3:0] rom_addr;
    logic       pll_locked, band_down, band_up;

    always #2 clk = ~clk;

    tuner_ctl_regs u0 (.*);

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // behavioural reference state
    int m_ser, m_par, m_fld, m_tfa, m_rb, m_lock, m_por, m_src, m_rd;

    function automatic int rom_of(int a);
        return (a * 29 + 7) % 256;
    endfunction

    function automatic int mread(int a);
        case (a)
            7:  return m_ser;
            8:  return m_fld * 128 + m_par;
            9:  return m_tfa;
            11: return m_rb;
            12: return m_por * 128 + m_lock * 16;
            default: return 0;
        endcase
    endfunction

    task automatic model_step();
        int n_rd, n_src, n_por, n_ser, n_par, n_fld, n_tfa, n_rb;
        if (!rst_n) begin
            m_ser = 15; m_par = 9; m_fld = 0; m_tfa = 0; m_rb = 0;
            m_lock = 0; m_por = 1; m_src = 0; m_rd = 0;
            return;
        end
        n_rd = m_rd; n_src = m_src; n_por = m_por;
        n_ser = m_ser; n_par = m_par; n_fld = m_fld; n_tfa = m_tfa; n_rb = m_rb;
        if (rd_stb) begin
            n_rd  = mread(int'(rd_addr));
            n_src = (rd_addr == 4'd12) ? 1 : 0;
        end
        if (rd_done && m_src == 1) n_por = 0;
        if (wr_stb) begin
            if (wr_addr == 4'd7) n_ser = int'(wr_data);
            if (wr_addr == 4'd8) begin
                n_par = int'(wr_data) % 64;
                n_fld = int'(wr_data[7]);
                if (wr_data[7] && m_fld == 0) n_rb = rom_of(m_tfa);
            end
            if (wr_addr == 4'd9) n_tfa = int'(wr_data) % 16;
        end
        m_rd = n_rd; m_src = n_src; m_por = n_por; m_ser = n_ser; m_par = n_par;
        m_fld = n_fld; m_tfa = n_tfa; m_rb = n_rb; m_lock = int'(pll_lock);
    endtask

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2 series_cap", int'(series_cap), m_ser);
        chk("R3 par_cap", int'(par_cap), m_par);
        chk("R3 rom_addr", int'(rom_addr), m_tfa);
        chk("R7 rd_data", int'(rd_data), m_rd);
        chk("R10 band_down", int'(band_down), (m_lock == 0) ? 1 : 0);
        chk("R10 band_up", int'(band_up), (m_lock == 7) ? 1 : 0);
        chk("R10 pll_locked", int'(pll_locked), (m_lock != 0 && m_lock != 7) ? 1 : 0);
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_wr(int a, int d);
        wr_stb = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
        tick();
        wr_stb = 1'b0;
    endtask

    task automatic do_rd(int a);
        rd_stb = 1'b1; rd_addr = 4'(a);
        tick();
        rd_stb = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk("R1 series reset", int'(series_cap), 8'h0F);
        chk("R1 par reset", int'(par_cap), 6'h09);
        chk("R1 rd_data reset", int'(rd_data), 0);
        do_rd(8);  chk("R1 reg8 reset", int'(rd_data), 8'h09);
        do_rd(11); chk("R1 readback reset", int'(rd_data), 8'h00);

        // R8/R9 status and power-on flag
        do_rd(12); chk("R8 status first read", int'(rd_data), 8'hA0);
        tick();
        do_rd(12); chk("R9 flag kept without rd_done", int'(rd_data), 8'hA0);
        rd_done = 1'b1; tick(); rd_done = 1'b0;
        do_rd(12); chk("R9 flag cleared after delivery", int'(rd_data), 8'h20);
        // rd_done after a non-status read must not matter; flag stays 0
        do_rd(7); rd_done = 1'b1; tick(); rd_done = 1'b0;
        do_rd(12); chk("R9 flag stays clear", int'(rd_data), 8'h20);

        // R2 series code
        do_wr(7, 8'hA5); do_rd(7); chk("R2 series readback", int'(rd_data), 8'hA5);
        chk("R2 series port", int'(series_cap), 8'hA5);

        // R3 parallel code and ROM address
        do_wr(8, 8'h7F); do_rd(8); chk("R3 reg8 reserved bit zero", int'(rd_data), 8'h3F);
        do_wr(9, 8'hFB); do_rd(9); chk("R3 reg9 upper zero", int'(rd_data), 8'h0B);
        chk("R3 rom_addr port", int'(rom_addr), 4'hB);

        // R4 load on rising edge of load bit
        do_wr(8, 8'h95); do_rd(11); chk("R4 load word addr 11", int'(rd_data), 8'h46);
        do_rd(8); chk("R3 reg8 with load bit", int'(rd_data), 8'h95);
        // R5 rewrite with load bit already 1
        do_wr(9, 8'h03); do_wr(8, 8'h95); do_rd(11);
        chk("R5 no reload while bit high", int'(rd_data), 8'h46);
        do_wr(8, 8'h15); do_rd(11); chk("R5 clearing bit no reload", int'(rd_data), 8'h46);
        do_wr(8, 8'h95); do_rd(11); chk("R4 load word addr 3", int'(rd_data), 8'h5E);
        do_wr(8, 8'h15); do_wr(9, 8'h00); do_wr(8, 8'h80); do_rd(11);
        chk("R4 load word addr 0", int'(rd_data), 8'h07);

        // R6 ignored writes
        do_wr(11, 8'hFF); do_wr(12, 8'hFF); do_wr(10, 8'h5A);
        do_wr(0, 8'h33); do_wr(15, 8'h44); do_wr(4, 8'h55);
        do_rd(11); chk("R6 readback not writable", int'(rd_data), 8'h07);
        do_rd(12); chk("R6 status not writable", int'(rd_data), 8'h20);
        do_rd(10); chk("R6 reserved reads zero", int'(rd_data), 0);
        do_rd(0);  chk("R6 unmapped reads zero", int'(rd_data), 0);
        do_rd(15); chk("R6 unmapped high reads zero", int'(rd_data), 0);
        do_rd(7);  chk("R6 series untouched", int'(rd_data), 8'hA5);

        // R7 same-cycle read and write returns old value; hold afterwards
        wr_stb = 1'b1; wr_addr = 4'd7; wr_data = 8'h11;
        rd_stb = 1'b1; rd_addr = 4'd7;
        tick();
        wr_stb = 1'b0; rd_stb = 1'b0;
        chk("R7 read before write", int'(rd_data), 8'hA5);
        tick(); tick();
        chk("R7 rd_data held", int'(rd_data), 8'hA5);
        do_rd(7); chk("R7 new value after write", int'(rd_data), 8'h11);

        // R10 and R8 lock indicator sweep
        pll_lock = 3'b000; tick(); tick();
        chk("R10 band_down for 000", int'(band_down), 1);
        pll_lock = 3'b111; tick(); tick();
        chk("R10 band_up for 111", int'(band_up), 1);
        do_rd(12); chk("R8 status lock 111", int'(rd_data), 8'h70);
        pll_lock = 3'b101; tick(); tick();
        chk("R10 locked for 101", int'(pll_locked), 1);
        for (int k = 0; k < 8; k++) begin
            pll_lock = 3'(k); tick(); tick();
            do_rd(12); chk("R8 status lock sweep", int'(rd_data), k * 16);
        end

        // second reset restores flag and defaults (R1, R9)
        pll_lock = 3'b011;
        do_reset();
        chk("R1 series after reset", int'(series_cap), 8'h0F);
        do_rd(12); chk("R9 flag set again by reset", int'(rd_data), 8'hB0);
        do_rd(11); chk("R1 readback after reset", int'(rd_data), 0);

        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

endmodule